// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register File

This block holds the digital state of a four-channel converter. Each command arrives already deframed: a 3-bit opcode, a 3-bit channel address, a 12-bit data word and a one-cycle valid strobe. Every channel has two stages. A staging register takes new data from the bus. An output register holds the code that drives the channel. A per-channel pending flag records that new data is waiting. An output register takes the staged value only when that flag is set. An untouched channel is never rewritten, so it produces no needless digital activity.

Data moves from the staging stage to the output stage in three ways. A bus command can request the move for one channel or for all of them. An active-low load pin, synchronised inside the block, makes the output registers follow their staging registers for as long as the pin is held low. A per-channel override mask makes the selected channels act as if the pin were low. The block also stores a 2-bit power-down mode for each channel and a reference-enable bit. It has a clear command that returns all of its state to zero.

Top module: `dac_regfile_ctl`

## Requirements
- R1: Opcode 000 stores the data word in the staging register of the addressed channel and sets that channel's pending flag. The output code does not change while the synchronised pin is high and the channel's mask bit is clear.
- R2: Opcode 001 copies the staging register of the addressed channel into its output register if the channel is pending. A channel that is not pending keeps its code.
- R3: Opcode 010 writes the addressed channel's staging register. In the same cycle, every pending channel, including the one just written, moves its staging value to its output.
- R4: Opcode 011 writes the addressed channel and moves the value to its output. The new code appears one clock after the command.
- R5: Address values 000 to 011 select channels A to D. Address 111 selects all four channels. Address values 100 to 110 make opcodes 000 to 011 have no effect.
- R6: The load pin passes through two synchroniser flops. While the synchronised level is low, every pending channel moves to its output on each clock, so a code change appears three clocks after the pin falls. While the level is high, the outputs hold.
- R7: Opcode 101 clears every staging register, output code, pending flag, mask bit, power-down mode and the reference-enable bit to zero.
- R8: Opcode 110 loads the mask from data bits 3:0, with bit i for channel i. A channel whose mask bit is set behaves as if the load pin were low.
- R9: Opcode 100 writes data bits 5:4 as the power-down mode of each channel i whose data bit i is set. The mode of channel i appears on pd_mode bits 2i+1:2i. Opcode 111 sets ref_on from data bit 0. Neither opcode changes any output code.
- R10: After reset, all codes, power-down modes and ref_on are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe that marks a command |
| cmd_op | input | 3 | Command opcode |
| cmd_ch | input | 3 | Channel address |
| cmd_data | input | 12 | Command data word |
| load_n | input | 1 | Asynchronous active-low load pin |
| dac_code | output | 48 | Output codes, channel A in bits 11:0 and channel D in bits 47:36 |
| pd_mode | output | 8 | Power-down mode of each channel, 2 bits per channel |
| ref_on | output | 1 | Reference-enable bit |

## Verification
Every bus command takes effect at the clock edge where it is presented. Its result is visible one cycle later. A change on the load pin reaches the codes at the third rising edge after it, because it passes through the two synchroniser flops first. The bench drives inputs on falling edges. It advances a reference model exactly once per rising edge, with the model's own two-stage copy of the pin. It compares every output against the model on the next falling edge, so both delays are respected without any per-case timing.

// File: rtl/dac_regfile_ctl.sv
module dac_regfile_ctl #(
  parameter int DW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [2:0]      cmd_ch,
  input  logic [DW-1:0]   cmd_data,
  input  logic            load_n,
  output logic [4*DW-1:0] dac_code,
  output logic [7:0]      pd_mode,
  output logic            ref_on
);
  localparam int NCH = 4;

  logic ld_s1, ld_s2;
  logic [NCH-1:0] mask_q, dirty_v;

  wire addr_ok = (cmd_ch < 3'd4) || (cmd_ch == 3'd7);
  wire is_wr   = cmd_valid && addr_ok && (cmd_op == 3'd0 || cmd_op == 3'd2 || cmd_op == 3'd3);
  wire clr     = cmd_valid && cmd_op == 3'd5;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_s1 <= 1'b1;
      ld_s2 <= 1'b1;
    end else begin
      ld_s1 <= load_n;
      ld_s2 <= ld_s1;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] in_q, dac_q, in_n;
    logic dirty_q, dirty_n, sel, wr, upd;

    assign sel     = (cmd_ch == 3'd7) || (cmd_ch == 3'(i));
    assign wr      = is_wr && sel;
    assign upd     = (cmd_valid && addr_ok &&
                      ((sel && (cmd_op == 3'd1 || cmd_op == 3'd3)) || cmd_op == 3'd2))
                     || !ld_s2 || mask_q[i];
    assign in_n    = wr ? cmd_data : in_q;
    assign dirty_n = wr | dirty_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        in_q    <= '0;
        dac_q   <= '0;
        dirty_q <= 1'b0;
      end else if (clr) begin
        in_q    <= '0;
        dac_q   <= '0;
        dirty_q <= 1'b0;
      end else begin
        in_q <= in_n;
        if (upd && dirty_n) begin
          dac_q   <= in_n;
          dirty_q <= 1'b0;
        end else begin
          dirty_q <= dirty_n;
        end
      end

    assign dac_code[i*DW +: DW] = dac_q;
    assign dirty_v[i]           = dirty_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q  <= '0;
      pd_mode <= '0;
      ref_on  <= 1'b0;
    end else if (clr) begin
      mask_q  <= '0;
      pd_mode <= '0;
      ref_on  <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_op)
        3'd6: mask_q <= cmd_data[NCH-1:0];
        3'd7: ref_on <= cmd_data[0];
        3'd4:
          for (int k = 0; k < NCH; k++)
            if (cmd_data[k]) pd_mode[2*k +: 2] <= cmd_data[5:4];
        default: ;
      endcase
    end
endmodule

module dac_regfile_ctl_chk #(
  parameter int DW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic [2:0]      cmd_ch,
  input logic [DW-1:0]   cmd_data,
  input logic            ld_s2,
  input logic [3:0]      mask_q,
  input logic [3:0]      dirty_v,
  input logic [4*DW-1:0] dac_code,
  input logic [7:0]      pd_mode,
  input logic            ref_on
);
  p_write_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0 && cmd_ch == 3'd0 && ld_s2 && !mask_q[0])
    |=> (dirty_v[0] && $stable(dac_code[DW-1:0])));

  p_write_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && cmd_ch == 3'd1)
    |=> (dac_code[2*DW-1:DW] == $past(cmd_data) && !dirty_v[1]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && ld_s2 && mask_q == 4'd0) |=> $stable(dac_code));

  p_pin_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s2 |=> dirty_v == 4'd0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5)
    |=> (dac_code == '0 && dirty_v == 4'd0 && mask_q == 4'd0 && pd_mode == 8'd0 && !ref_on));

  p_side_cmds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd7) && ld_s2 && mask_q == 4'd0)
    |=> $stable(dac_code));
endmodule

bind dac_regfile_ctl dac_regfile_ctl_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_dac_regfile_ctl.sv
module tb_dac_regfile_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, load_n = 1'b1;
  logic [2:0] cmd_op = '0, cmd_ch = '0;
  logic [11:0] cmd_data = '0;
  logic [47:0] dac_code;
  logic [7:0] pd_mode;
  logic ref_on;

  int errors = 0, checks = 0;
  logic [11:0] m_in [4], m_dac [4];
  logic [3:0] m_dirty = '0, m_mask = '0;
  logic [7:0] m_pd = '0;
  logic m_ref = 1'b0, m_s1 = 1'b1, m_s2 = 1'b1;

  dac_regfile_ctl dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [47:0] exp_codes();
    return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
  endfunction

  task automatic model_edge(input logic v, input logic [2:0] op, ch, input logic [11:0] d);
    logic ld_low = !m_s2;
    logic aok = (ch < 3) || (ch == 3'd7) || (ch == 3'd3);
    m_s2 = m_s1;
    m_s1 = load_n;
    if (v && op == 3'd5) begin
      for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
      m_dirty = '0; m_mask = '0; m_pd = '0; m_ref = 1'b0;
      return;
    end
    for (int i = 0; i < 4; i++) begin
      logic sel = (ch == 3'd7) || (ch == 3'(i));
      logic wr = v && aok && sel && (op == 3'd0 || op == 3'd2 || op == 3'd3);
      logic up = (v && aok && ((sel && (op == 3'd1 || op == 3'd3)) || op == 3'd2))
                 || ld_low || m_mask[i];
      if (wr) begin m_in[i] = d; m_dirty[i] = 1'b1; end
      if (up && m_dirty[i]) begin m_dac[i] = m_in[i]; m_dirty[i] = 1'b0; end
    end
    if (v && op == 3'd6) m_mask = d[3:0];
    if (v && op == 3'd7) m_ref = d[0];
    if (v && op == 3'd4)
      for (int k = 0; k < 4; k++) if (d[k]) m_pd[2*k +: 2] = d[5:4];
  endtask

  task automatic check(input string tag);
    checks++;
    if (dac_code !== exp_codes() || pd_mode !== m_pd || ref_on !== m_ref) begin
      errors++;
      $display("FAIL %s: got codes=%h pd=%h ref=%b, expected codes=%h pd=%h ref=%b",
               tag, dac_code, pd_mode, ref_on, exp_codes(), m_pd, m_ref);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] op, ch,
                      input logic [11:0] d);
    cmd_valid = v; cmd_op = op; cmd_ch = ch; cmd_data = d;
    @(posedge clk);
    model_edge(v, op, ch, d);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag, 1'b0, 3'd0, 3'd0, 12'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset state");

    step("R1 stage only", 1'b1, 3'd0, 3'd0, 12'hA5A);
    idle("R1 hold", 2);
    step("R2 update A", 1'b1, 3'd1, 3'd0, 12'h000);
    step("R2 update clean B", 1'b1, 3'd1, 3'd1, 12'h000);
    step("R4 write+update C", 1'b1, 3'd3, 3'd2, 12'h3C3);
    step("R3 stage D", 1'b1, 3'd0, 3'd3, 12'h111);
    step("R3 write B update all", 1'b1, 3'd2, 3'd1, 12'h777);
    step("R5 bad address", 1'b1, 3'd3, 3'd5, 12'hFFF);
    step("R5 all channels", 1'b1, 3'd3, 3'd7, 12'h0F0);
    step("R9 power-down", 1'b1, 3'd4, 3'd0, 12'h025);
    step("R9 reference", 1'b1, 3'd7, 3'd0, 12'h001);
    step("R6 stage A", 1'b1, 3'd0, 3'd0, 12'h999);
    load_n = 1'b0;
    idle("R6 pin low", 4);
    step("R6 follow while low", 1'b1, 3'd0, 3'd2, 12'h444);
    load_n = 1'b1;
    idle("R6 pin high", 3);
    step("R6 hold high", 1'b1, 3'd0, 3'd1, 12'h222);
    idle("R6 hold high", 2);
    step("R8 mask B", 1'b1, 3'd6, 3'd0, 12'h002);
    step("R8 masked write B", 1'b1, 3'd0, 3'd1, 12'h5AB);
    step("R8 unmasked write D", 1'b1, 3'd0, 3'd3, 12'h6CD);
    step("R7 clear", 1'b1, 3'd5, 3'd0, 12'h000);
    step("R7 after clear", 1'b1, 3'd1, 3'd7, 12'h000);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [2:0] ch = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 6))
                     : (($urandom_range(0, 5) == 0) ? 3'd7 : 3'($urandom_range(0, 3)));
      if (op == 3'd5 && $urandom_range(0, 3) != 0) op = 3'd0;
      if ($urandom_range(0, 40) == 0) load_n = ~load_n;
      step("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", $urandom_range(0, 2) != 0, op, ch,
           12'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule